// File: doc/BRIEF.md
# Paged Stack Pointer with Context Push/Pop Sequencer

This block keeps a CPU stack pointer whose upper byte is fixed, so every stack access lands inside one 256-byte page. It turns single commands into ordered byte transfers on a byte-wide memory port. A push writes at the current pointer and then moves the pointer down. A pop moves the pointer up and reads at the new position. Past either end of the page the pointer wraps with no warning.

On top of single-byte push and pop, the block runs four multi-byte sequences, one byte per clock. A call stores a 2-byte return address, and a return brings it back. An interrupt entry stores a 5-byte context (program counter low, program counter high, X, A, condition codes), and an interrupt return unwinds it in reverse order. There are also two direct commands: one loads the pointer's low byte, the other puts the pointer back to the top of the page. The restored register values are held on output ports.

The memory read port is combinational: `mem_rdata` must reflect `mem_addr` in the same cycle. While a sequence runs, `busy` is high and any new command is ignored.

Top module: `stack_ctx_seq`

## Requirements
- R1: The upper byte of `sp_out` and of `mem_addr` is always 8'h01, so every stack access falls in 0100h..01FFh.
- R2: After reset, and one cycle after an accepted reset-pointer command (op 7), `sp_out` is 16'h01FF.
- R3: Push (op 0) writes `cmd_data` at `sp_out` in the cycle after acceptance and then decrements the pointer. Pop (op 1) reads at `sp_out`+1 in the cycle after acceptance, increments the pointer and shows the byte on `pop_data`.
- R4: Decrementing from 0100h gives 01FFh, and incrementing from 01FFh gives 0100h; no flag or other output marks either wrap.
- R5: Call (op 2) writes the low byte of `pc_in` and then its high byte in two consecutive cycles, leaving the pointer lower by 2. Return (op 4) pops the high byte and then the low byte into `pc_out`.
- R6: Interrupt entry (op 3) writes exactly five bytes on consecutive cycles, starting the cycle after acceptance, in the order PC low, PC high, X, A, CC. No Y value is stored.
- R7: Interrupt return (op 5) pops five bytes in the order CC, A, X, PC high, PC low into `cc_out`, `a_out`, `x_out` and `pc_out`, leaving the pointer higher by 5.
- R8: Load-low (op 6) replaces only the low byte of the pointer with `cmd_data`, effective the next cycle.
- R9: `busy` is high for exactly as many cycles as the accepted sequence transfers bytes (1, 2 or 5). A command presented while `busy` is high causes no memory write and no pointer change.
- R10: `done` pulses for one cycle in the first cycle after a sequence's last byte, with `busy` low and the restored outputs already valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present; accepted when busy is low |
| cmd_op | input | 3 | Command code (see requirements) |
| cmd_data | input | 8 | Push byte or new pointer low byte |
| pc_in | input | 16 | Program counter to save |
| x_in | input | 8 | X register to save |
| a_in | input | 8 | Accumulator to save |
| cc_in | input | 8 | Condition codes to save |
| mem_rdata | input | 8 | Read data for mem_addr (combinational) |
| mem_addr | output | 16 | Stack memory address |
| mem_wdata | output | 8 | Stack memory write data |
| mem_we | output | 1 | Stack memory write enable |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse after a sequence ends |
| sp_out | output | 16 | Current stack pointer |
| pop_data | output | 8 | Byte from the last single pop |
| pc_out | output | 16 | Restored program counter |
| x_out | output | 8 | Restored X |
| a_out | output | 8 | Restored accumulator |
| cc_out | output | 8 | Restored condition codes |

## Verification
The hardest case to reach from the ports is a wrap in the middle of a transfer: a push from the bottom of the page and a pop from the top must cross the page boundary. The bench gets there by using load-low to place the pointer at 00h and FFh first.

A second hard case is a command that arrives while a multi-byte sequence is running. The bench holds `cmd_valid` high through a whole interrupt entry. The scoreboard then flags any sixth write, and the pointer is compared afterwards.

// File: rtl/stack_ctx_pkg.sv
package stack_ctx_pkg;
    localparam int DW = 8;
    localparam int AW = 2 * DW;

    typedef enum logic [2:0] {
        OP_PUSH  = 3'd0,
        OP_POP   = 3'd1,
        OP_CALL  = 3'd2,
        OP_INT   = 3'd3,
        OP_RET   = 3'd4,
        OP_IRET  = 3'd5,
        OP_LDLO  = 3'd6,
        OP_RSTSP = 3'd7
    } op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WR_BYTE,
        ST_RD_BYTE,
        ST_WR_PCL,
        ST_WR_PCH,
        ST_WR_X,
        ST_WR_A,
        ST_WR_CC,
        ST_RD_CC,
        ST_RD_A,
        ST_RD_X,
        ST_RD_PCH,
        ST_RD_PCL
    } seq_state_e;

    typedef enum logic [2:0] {
        DST_NONE,
        DST_BYTE,
        DST_PCL,
        DST_PCH,
        DST_X,
        DST_A,
        DST_CC
    } dest_e;
endpackage

// File: rtl/sp_pointer.sv
module sp_pointer
    import stack_ctx_pkg::*;
#(
    parameter logic [DW-1:0] PAGE   = 8'h01,
    parameter logic [DW-1:0] TOP_LO = 8'hFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rst_sp,
    input  logic          ld_lo,
    input  logic [DW-1:0] ld_val,
    input  logic          dec,
    input  logic          inc,
    output logic [AW-1:0] sp,
    output logic [AW-1:0] sp_up
);
    logic [DW-1:0] lo_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= TOP_LO;
        end else if (rst_sp) begin
            lo_q <= TOP_LO;
        end else if (ld_lo) begin
            lo_q <= ld_val;
        end else if (dec) begin
            lo_q <= lo_q - 8'd1;
        end else if (inc) begin
            lo_q <= lo_q + 8'd1;
        end
    end

    logic [DW-1:0] lo_up;
    assign lo_up = lo_q + 8'd1;
    assign sp    = {PAGE, lo_q};
    assign sp_up = {PAGE, lo_up};
endmodule

// File: rtl/ctx_restore.sv
module ctx_restore
    import stack_ctx_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  dest_e         dest,
    input  logic [DW-1:0] rdata,
    output logic [DW-1:0] pop_data,
    output logic [AW-1:0] pc_out,
    output logic [DW-1:0] x_out,
    output logic [DW-1:0] a_out,
    output logic [DW-1:0] cc_out
);
    logic [DW-1:0] pcl_q, pch_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pop_data <= '0;
            pcl_q    <= '0;
            pch_q    <= '0;
            x_out    <= '0;
            a_out    <= '0;
            cc_out   <= '0;
        end else begin
            unique case (dest)
                DST_BYTE: pop_data <= rdata;
                DST_PCL:  pcl_q    <= rdata;
                DST_PCH:  pch_q    <= rdata;
                DST_X:    x_out    <= rdata;
                DST_A:    a_out    <= rdata;
                DST_CC:   cc_out   <= rdata;
                default:  ;
            endcase
        end
    end

    assign pc_out = {pch_q, pcl_q};
endmodule

// File: rtl/ctx_seq_fsm.sv
module ctx_seq_fsm
    import stack_ctx_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [DW-1:0] cmd_data,
    input  logic [AW-1:0] pc_in,
    input  logic [DW-1:0] x_in,
    input  logic [DW-1:0] a_in,
    input  logic [DW-1:0] cc_in,
    output logic          busy,
    output logic          done,
    output logic          push_en,
    output logic          pop_en,
    output logic [DW-1:0] wdata,
    output dest_e         dest,
    output logic          ld_lo,
    output logic          rst_sp
);
    seq_state_e state_q, state_d;
    logic          accept;
    logic          is_int_q;
    logic [DW-1:0] byte_q, x_q, a_q, cc_q;
    logic [AW-1:0] pc_q;

    assign accept = cmd_valid && (state_q == ST_IDLE);
    assign ld_lo  = accept && (cmd_op == OP_LDLO);
    assign rst_sp = accept && (cmd_op == OP_RSTSP);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    unique case (cmd_op)
                        OP_PUSH: state_d = ST_WR_BYTE;
                        OP_POP:  state_d = ST_RD_BYTE;
                        OP_CALL: state_d = ST_WR_PCL;
                        OP_INT:  state_d = ST_WR_PCL;
                        OP_RET:  state_d = ST_RD_PCH;
                        OP_IRET: state_d = ST_RD_CC;
                        default: state_d = ST_IDLE;
                    endcase
                end
            end
            ST_WR_BYTE: state_d = ST_IDLE;
            ST_RD_BYTE: state_d = ST_IDLE;
            ST_WR_PCL:  state_d = ST_WR_PCH;
            ST_WR_PCH:  state_d = is_int_q ? ST_WR_X : ST_IDLE;
            ST_WR_X:    state_d = ST_WR_A;
            ST_WR_A:    state_d = ST_WR_CC;
            ST_WR_CC:   state_d = ST_IDLE;
            ST_RD_CC:   state_d = ST_RD_A;
            ST_RD_A:    state_d = ST_RD_X;
            ST_RD_X:    state_d = ST_RD_PCH;
            ST_RD_PCH:  state_d = ST_RD_PCL;
            ST_RD_PCL:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            done     <= 1'b0;
            is_int_q <= 1'b0;
            byte_q   <= '0;
            pc_q     <= '0;
            x_q      <= '0;
            a_q      <= '0;
            cc_q     <= '0;
        end else begin
            state_q <= state_d;
            done    <= (state_q != ST_IDLE) && (state_d == ST_IDLE);
            if (accept) begin
                is_int_q <= (cmd_op == OP_INT);
                byte_q   <= cmd_data;
                pc_q     <= pc_in;
                x_q      <= x_in;
                a_q      <= a_in;
                cc_q     <= cc_in;
            end
        end
    end

    always_comb begin
        busy    = (state_q != ST_IDLE);
        push_en = 1'b0;
        pop_en  = 1'b0;
        wdata   = '0;
        dest    = DST_NONE;
        unique case (state_q)
            ST_IDLE:    ;
            ST_WR_BYTE: begin push_en = 1'b1; wdata = byte_q;          end
            ST_WR_PCL:  begin push_en = 1'b1; wdata = pc_q[DW-1:0];    end
            ST_WR_PCH:  begin push_en = 1'b1; wdata = pc_q[AW-1:DW];   end
            ST_WR_X:    begin push_en = 1'b1; wdata = x_q;             end
            ST_WR_A:    begin push_en = 1'b1; wdata = a_q;             end
            ST_WR_CC:   begin push_en = 1'b1; wdata = cc_q;            end
            ST_RD_BYTE: begin pop_en = 1'b1; dest = DST_BYTE;          end
            ST_RD_CC:   begin pop_en = 1'b1; dest = DST_CC;            end
            ST_RD_A:    begin pop_en = 1'b1; dest = DST_A;             end
            ST_RD_X:    begin pop_en = 1'b1; dest = DST_X;             end
            ST_RD_PCH:  begin pop_en = 1'b1; dest = DST_PCH;           end
            ST_RD_PCL:  begin pop_en = 1'b1; dest = DST_PCL;           end
            default:    ;
        endcase
    end
endmodule

// File: rtl/stack_ctx_seq.sv
module stack_ctx_seq
    import stack_ctx_pkg::*;
#(
    parameter logic [7:0] PAGE   = 8'h01,
    parameter logic [7:0] TOP_LO = 8'hFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic [2:0]  cmd_op,
    input  logic [7:0]  cmd_data,
    input  logic [15:0] pc_in,
    input  logic [7:0]  x_in,
    input  logic [7:0]  a_in,
    input  logic [7:0]  cc_in,
    input  logic [7:0]  mem_rdata,
    output logic [15:0] mem_addr,
    output logic [7:0]  mem_wdata,
    output logic        mem_we,
    output logic        busy,
    output logic        done,
    output logic [15:0] sp_out,
    output logic [7:0]  pop_data,
    output logic [15:0] pc_out,
    output logic [7:0]  x_out,
    output logic [7:0]  a_out,
    output logic [7:0]  cc_out
);
    logic          push_en, pop_en, ld_lo, rst_sp;
    dest_e         dest;
    logic [AW-1:0] sp, sp_up;

    ctx_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_data  (cmd_data),
        .pc_in     (pc_in),
        .x_in      (x_in),
        .a_in      (a_in),
        .cc_in     (cc_in),
        .busy      (busy),
        .done      (done),
        .push_en   (push_en),
        .pop_en    (pop_en),
        .wdata     (mem_wdata),
        .dest      (dest),
        .ld_lo     (ld_lo),
        .rst_sp    (rst_sp)
    );

    sp_pointer #(.PAGE(PAGE), .TOP_LO(TOP_LO)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .rst_sp (rst_sp),
        .ld_lo  (ld_lo),
        .ld_val (cmd_data),
        .dec    (push_en),
        .inc    (pop_en),
        .sp     (sp),
        .sp_up  (sp_up)
    );

    ctx_restore u_rest (
        .clk      (clk),
        .rst_n    (rst_n),
        .dest     (dest),
        .rdata    (mem_rdata),
        .pop_data (pop_data),
        .pc_out   (pc_out),
        .x_out    (x_out),
        .a_out    (a_out),
        .cc_out   (cc_out)
    );

    assign mem_addr = pop_en ? sp_up : sp;
    assign mem_we   = push_en;
    assign sp_out   = sp;
endmodule

// File: rtl/stack_ctx_seq_chk.sv
module stack_ctx_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic [2:0]  cmd_op,
    input logic        busy,
    input logic        done,
    input logic        mem_we,
    input logic [15:0] mem_addr,
    input logic [15:0] sp_out
);
    logic acc;
    assign acc = cmd_valid && !busy;

    AST_FIXED_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_addr[15:8] == 8'h01) && (sp_out[15:8] == 8'h01)); // R1
    AST_RESET_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_op == 3'd7) |=> (sp_out == 16'h01FF)); // R2
    AST_PUSH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr == sp_out)); // R3
    AST_PUSH_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (sp_out[7:0] == $past(sp_out[7:0]) - 8'd1)); // R4
    AST_INT_START: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_op == 3'd3) |=> (busy && mem_we)); // R6
    AST_BUSY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ((sp_out[7:0] == $past(sp_out[7:0]) + 8'd1) ||
                  (sp_out[7:0] == $past(sp_out[7:0]) - 8'd1))); // R9
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !$past(done))); // R10
endmodule

bind stack_ctx_seq stack_ctx_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .busy      (busy),
    .done      (done),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .sp_out    (sp_out)
);

// File: tb/stack_ctx_seq_tb.sv
module stack_ctx_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [7:0]  cmd_data = 8'd0;
    logic [15:0] pc_in = 16'd0;
    logic [7:0]  x_in = 8'd0, a_in = 8'd0, cc_in = 8'd0;
    logic [7:0]  mem_rdata;
    logic [15:0] mem_addr, sp_out, pc_out;
    logic [7:0]  mem_wdata, pop_data, x_out, a_out, cc_out;
    logic        mem_we, busy, done;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [7:0]  mem [256];
    logic [23:0] exp_q [$];

    always #4 clk = ~clk;

    stack_ctx_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .pc_in(pc_in), .x_in(x_in), .a_in(a_in),
        .cc_in(cc_in), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .busy(busy), .done(done),
        .sp_out(sp_out), .pop_data(pop_data), .pc_out(pc_out),
        .x_out(x_out), .a_out(a_out), .cc_out(cc_out)
    );

    assign mem_rdata = mem[mem_addr[7:0]];
    always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: compares every memory write with the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R9 actual=%h expected=no write", {mem_addr, mem_wdata});
            end else begin
                logic [23:0] e;
                e = exp_q.pop_front();
                if ({mem_addr, mem_wdata} !== e) begin
                    errors++;
                    $display("FAIL R3/R5/R6 actual=%h expected=%h", {mem_addr, mem_wdata}, e);
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<20000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic expect_wr(input logic [15:0] addr, input logic [7:0] d);
        exp_q.push_back({addr, d});
    endtask

    // issue one command; returns the number of busy cycles; hold keeps
    // cmd_valid asserted (with a push) for the whole busy window
    task automatic issue(input logic [2:0] op, input logic [7:0] d,
                         input bit hold, output int nbusy);
        cmd_op = op; cmd_data = d; cmd_valid = 1'b1;
        @(negedge clk);
        if (hold) begin cmd_op = 3'd0; cmd_data = 8'hEE; end
        else cmd_valid = 1'b0;
        nbusy = 0;
        while (busy) begin
            nbusy++;
            @(negedge clk);
            if (!busy) cmd_valid = 1'b0;
        end
        cmd_valid = 1'b0;
    endtask

    initial begin
        int n;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 reset pointer", sp_out, 16'h01FF);
        chk("R9 reset busy", busy, 0);
        chk("R10 reset done", done, 0);

        expect_wr(16'h01FF, 8'hA5);
        issue(3'd0, 8'hA5, 0, n);
        chk("R9 push busy cycles", n, 1);
        chk("R3 push pointer", sp_out, 16'h01FE);
        chk("R10 push done", done, 1);

        issue(3'd1, 8'h00, 0, n);
        chk("R3 pop data", pop_data, 8'hA5);
        chk("R3 pop pointer", sp_out, 16'h01FF);

        pc_in = 16'h1234;
        expect_wr(16'h01FF, 8'h34); expect_wr(16'h01FE, 8'h12);
        issue(3'd2, 8'h00, 0, n);
        chk("R9 call busy cycles", n, 2);
        chk("R5 call pointer", sp_out, 16'h01FD);
        pc_in = 16'h0000;
        issue(3'd4, 8'h00, 0, n);
        chk("R5 return pc", pc_out, 16'h1234);
        chk("R5 return pointer", sp_out, 16'h01FF);

        pc_in = 16'hBEEF; x_in = 8'h11; a_in = 8'h22; cc_in = 8'h33;
        expect_wr(16'h01FF, 8'hEF); expect_wr(16'h01FE, 8'hBE);
        expect_wr(16'h01FD, 8'h11); expect_wr(16'h01FC, 8'h22);
        expect_wr(16'h01FB, 8'h33);
        issue(3'd3, 8'h00, 1, n);   // push held high while busy: R9 ignore
        chk("R9 interrupt busy cycles", n, 5);
        chk("R6 interrupt pointer", sp_out, 16'h01FA);
        chk("R10 interrupt done", done, 1);
        @(negedge clk);
        chk("R9 ignored push left pointer", sp_out, 16'h01FA);
        chk("R10 done single pulse", done, 0);
        chk("R6 all five bytes written", exp_q.size(), 0);

        pc_in = 16'h0; x_in = 8'h0; a_in = 8'h0; cc_in = 8'h0;
        issue(3'd5, 8'h00, 0, n);
        chk("R9 iret busy cycles", n, 5);
        chk("R7 iret cc", cc_out, 8'h33);
        chk("R7 iret a", a_out, 8'h22);
        chk("R7 iret x", x_out, 8'h11);
        chk("R7 iret pc", pc_out, 16'hBEEF);
        chk("R7 iret pointer", sp_out, 16'h01FF);

        issue(3'd6, 8'h00, 0, n);
        chk("R8 load low", sp_out, 16'h0100);
        chk("R8 load no busy", n, 0);
        expect_wr(16'h0100, 8'h5A);
        issue(3'd0, 8'h5A, 0, n);
        chk("R4 push wraps to top", sp_out, 16'h01FF);
        chk("R1 page kept", sp_out[15:8], 8'h01);
        issue(3'd1, 8'h00, 0, n);
        chk("R4 pop wraps to bottom", sp_out, 16'h0100);
        chk("R4 pop data after wrap", pop_data, 8'h5A);

        issue(3'd6, 8'h80, 0, n);
        chk("R8 load 80", sp_out, 16'h0180);
        issue(3'd7, 8'h00, 0, n);
        chk("R2 reset-pointer command", sp_out, 16'h01FF);

        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule